// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel of a timer. A 16-bit free-running counter advances once every four clocks, driven by a two-bit prescaler. The CPU loads a 16-bit compare value as two bytes over a simple byte bus with an address, a write strobe, a read strobe and write and read data. When the counter steps onto the compare value, the channel sets a match flag. If the channel's enable bit is set, the flag also raises an interrupt request.

The bus has two interlocks. A write to the high compare byte stops compares until the low byte is written, so software can change both bytes without a false match on a half-updated value. The flag is cleared by a two-step handshake: first a read of the status byte while the flag is set, then a write of the low compare byte. Reset does not initialise the compare value or the flag. Software must bring them to a known state with a high-byte write, a status read and a low-byte write.

Top module: `ocmp_channel`

## Requirements
- R1: While reset is held and just after it, the counter reads back as 0xFFFC (high byte at address 2, low byte at address 3), the control byte at address 0 reads 0x00 and the interrupt is low. Reset also clears the prescaler, the compare suspension and the clear arming. Reset leaves the compare bytes and the flag as they were.
- R2: The counter advances by exactly one every four clocks. The first step comes on the fourth rising edge after reset is released, and the count wraps from 0xFFFF to 0x0000.
- R3: The flag is status bit 5 (address 1). It becomes 1 on a counter-advance edge when the new count equals the compare value (high byte at address 4, low byte at address 5) and compares are not suspended.
- R4: The interrupt is high exactly when the flag is 1 and the enable bit is 1. The enable bit is control bit 5 at address 0 and is writable and readable. The other control and status bits read 0.
- R5: A write to address 4 suspends compares from the next edge until a write to address 5. No match sets the flag while compares are suspended.
- R6: A write to address 5 alone does not suspend compares.
- R7: Writing one compare byte leaves the other byte unchanged. Both bytes read back what was written.
- R8: A status read that sees the flag at 1 arms the clear. The next write to address 5 clears the flag and disarms. A write to address 5 without arming leaves the flag at 1.
- R9: If a match and an armed clearing write fall on the same edge, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Byte register address |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe, arms the flag clear |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed byte |
| irq_o | output | 1 | Compare interrupt request |

## Verification
The properties assume the bus never asserts read and write strobes together. They also assume the bus stays idle while reset is held, so that no byte write or arming read lands on an edge that reset masks. The bench keeps to this by issuing one operation at a time with an idle cycle after it, and by leaving the bus idle during reset.

The flag starts undetermined, so the reference model learns its value from the first status read. It does not compare the interrupt before that read. It tracks compare bytes as unknown until each has been written.

// File: rtl/ocmp_channel.sv
module ocmp_channel #(
  parameter int unsigned CNT_W     = 16,
  parameter logic [15:0] CNT_RESET = 16'hFFFC,
  parameter int unsigned PRE_W     = 2,
  parameter int unsigned FLAG_BIT  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_o
);
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_CNTH = 3'd2;
  localparam logic [2:0] A_CNTL = 3'd3;
  localparam logic [2:0] A_CMPH = 3'd4;
  localparam logic [2:0] A_CMPL = 3'd5;

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [15:0]      cmp_q;
  logic             flag_q, armed_q, hold_q, ien_q;

  wire             tick    = &pre_q;
  wire [CNT_W-1:0] cnt_nxt = cnt_q + 1'b1;
  wire             wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire             wr_hi   = bus_wr && bus_addr == A_CMPH;
  wire             wr_lo   = bus_wr && bus_addr == A_CMPL;
  wire             rd_stat = bus_rd && bus_addr == A_STAT;
  wire             hit     = tick && !hold_q && cnt_nxt == cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      cnt_q   <= CNT_RESET;
      hold_q  <= 1'b0;
      armed_q <= 1'b0;
      ien_q   <= 1'b0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (tick) cnt_q <= cnt_nxt;
      if (wr_hi) hold_q <= 1'b1;
      else if (wr_lo) hold_q <= 1'b0;
      if (wr_lo) armed_q <= 1'b0;
      else if (rd_stat && flag_q) armed_q <= 1'b1;
      if (wr_ctrl) ien_q <= bus_wdata[FLAG_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_hi) cmp_q[15:8] <= bus_wdata;
    if (wr_lo) cmp_q[7:0]  <= bus_wdata;
    if (hit) flag_q <= 1'b1;
    else if (wr_lo && armed_q) flag_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = 8'h00;
    case (bus_addr)
      A_CTRL:  bus_rdata[FLAG_BIT] = ien_q;
      A_STAT:  bus_rdata[FLAG_BIT] = flag_q;
      A_CNTH:  bus_rdata = cnt_q[15:8];
      A_CNTL:  bus_rdata = cnt_q[7:0];
      A_CMPH:  bus_rdata = cmp_q[15:8];
      A_CMPL:  bus_rdata = cmp_q[7:0];
      default: bus_rdata = 8'h00;
    endcase
  end

  assign irq_o = flag_q & ien_q;
endmodule

// File: rtl/ocmp_channel_chk.sv
module ocmp_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  bus_addr,
  input logic        bus_wr,
  input logic [15:0] cnt,
  input logic [15:0] cmp,
  input logic        flag,
  input logic        armed,
  input logic        hold,
  input logic        tick
);
  wire lo_wr = bus_wr && bus_addr == 3'd5;
  wire hi_wr = bus_wr && bus_addr == 3'd4;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 16'd1)); // R2
  AST_COUNT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == $past(cnt) + 16'd1)); // R2
  AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hold && (cnt + 16'd1) == cmp) |=> flag); // R3
  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> !$past(hold)); // R5
  AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> $stable(cmp[15:8])); // R7
  AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> $stable(cmp[7:0])); // R7
  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(armed && lo_wr)); // R8
endmodule

bind ocmp_channel ocmp_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .cnt(cnt_q), .cmp(cmp_q), .flag(flag_q), .armed(armed_q),
  .hold(hold_q), .tick(tick)
);

// File: tb/ocmp_channel_tb.sv
module ocmp_channel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_o;

  ocmp_channel u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  int        m_pre;
  logic [15:0] m_cnt, m_cmp;
  bit m_flag, m_armed, m_hold, m_ien, flag_known, hi_known, lo_known;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {2'b00, m_ien, 5'b0};
      3'd1: return {2'b00, m_flag, 5'b0};
      3'd2: return m_cnt[15:8];
      3'd3: return m_cnt[7:0];
      3'd4: return m_cmp[15:8];
      3'd5: return m_cmp[7:0];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 16'hFFFC; m_hold = 0; m_armed = 0; m_ien = 0;
    end else begin
      bit tk, hit, lo, hi;
      logic [15:0] nx;
      tk = (m_pre == 3);
      nx = m_cnt + 16'd1;
      lo = bus_wr && bus_addr == 3'd5;
      hi = bus_wr && bus_addr == 3'd4;
      hit = tk && !m_hold && hi_known && lo_known && nx == m_cmp;
      if (hit) m_flag = 1;
      else if (lo && m_armed) begin m_flag = 0; flag_known = 1; end
      if (lo) m_armed = 0;
      else if (bus_rd && bus_addr == 3'd1 && m_flag && flag_known) m_armed = 1;
      if (hi) begin m_hold = 1; m_cmp[15:8] = bus_wdata; hi_known = 1; end
      else if (lo) m_hold = 0;
      if (lo) begin m_cmp[7:0] = bus_wdata; lo_known = 1; end
      if (bus_wr && bus_addr == 3'd0) m_ien = bus_wdata[5];
      if (tk) m_cnt = nx;
      m_pre = (m_pre + 1) % 4;
    end
  end

  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      if (flag_known) chk("R4 irq vs model", irq_o, m_flag && m_ien);
      if (bus_rd) begin
        case (bus_addr)
          3'd0: chk("R4 control readback", bus_rdata, m_read(3'd0));
          3'd1: if (flag_known) chk("R3 status readback", bus_rdata, m_read(3'd1));
          3'd2, 3'd3: chk("R2 counter readback", bus_rdata, m_read(bus_addr));
          3'd4: if (hi_known) chk("R7 compare high readback", bus_rdata, m_read(3'd4));
          3'd5: if (lo_known) chk("R7 compare low readback", bus_rdata, m_read(3'd5));
          default: chk("R4 unused address", bus_rdata, 0);
        endcase
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #5 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic learn_flag();
    @(negedge clk); bus_rd = 1; bus_addr = 3'd1;
    #5 m_flag = bus_rdata[5]; flag_known = 1;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cmp(input logic [15:0] v);
    wr(3'd4, v[15:8]);
    wr(3'd5, v[7:0]);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [15:0] t;
    repeat (3) @(negedge clk);
    bus_addr = 3'd2; #1 chk("R1 counter high in reset", bus_rdata, 8'hFF);
    bus_addr = 3'd3; #1 chk("R1 counter low in reset", bus_rdata, 8'hFC);
    bus_addr = 3'd0; #1 chk("R1 control in reset", bus_rdata, 8'h00);
    chk("R1 irq in reset", irq_o, 0);
    @(negedge clk); rst_n = 1;
    // R2: edges 1..3 hold the count, edge 4 steps it
    repeat (3) @(posedge clk);
    #5 bus_addr = 3'd3; #1 chk("R2 count held before fourth edge", bus_rdata, 8'hFC);
    @(posedge clk); #5 chk("R2 count after fourth edge", bus_rdata, 8'hFD);
    repeat (4) @(posedge clk); #5 chk("R2 count after eighth edge", bus_rdata, 8'hFE);
    // safe initialisation
    wr(3'd4, 8'h80);
    learn_flag();
    wr(3'd5, 8'h00);
    rd(3'd1, d); chk("R8 flag clear after init", d, 8'h00);
    wr(3'd0, 8'h20);
    rd(3'd0, d); chk("R4 enable readback", d, 8'h20);
    idle(8);
    rd(3'd2, d); rd(3'd3, d);
    // R3/R4 match with enable set
    t = m_cnt + 16'd4; set_cmp(t); idle(24);
    chk("R3 flag set raises irq", irq_o, 1);
    // R8 unarmed low write keeps the flag
    wr(3'd5, t[7:0]); idle(2);
    chk("R8 unarmed write keeps flag", irq_o, 1);
    rd(3'd1, d); chk("R3 status shows flag", d, 8'h20);
    wr(3'd5, 8'hF0); idle(1);
    chk("R8 armed write clears flag", irq_o, 0);
    rd(3'd1, d); chk("R8 status clear", d, 8'h00);
    // R4 enable off: flag sets, irq stays low
    wr(3'd0, 8'h00);
    t = m_cnt + 16'd4; set_cmp(t); idle(24);
    chk("R4 irq low with enable off", irq_o, 0);
    rd(3'd1, d); chk("R3 flag set with enable off", d, 8'h20);
    wr(3'd5, 8'hF0);
    wr(3'd0, 8'h20);
    rd(3'd1, d); chk("R8 cleared again", d, 8'h00);
    // R5 suspension after high write
    t = m_cnt + 16'd10;
    wr(3'd5, t[7:0]);
    wr(3'd4, t[15:8]);
    idle(48);
    chk("R5 no match while suspended", irq_o, 0);
    rd(3'd1, d); chk("R5 status clear while suspended", d, 8'h00);
    wr(3'd5, t[7:0]);
    // R6 low-only write keeps comparing
    t = m_cnt + 16'd8;
    if (t[15:8] != m_cmp[15:8]) wr(3'd4, t[15:8]);
    if (t[15:8] != m_cmp[15:8]) t = m_cnt + 16'd8;
    wr(3'd5, t[7:0]); idle(40);
    chk("R6 low-only write still matches", irq_o, 1);
    // R9 match and armed clear on the same edge
    t = m_cnt + 16'd10;
    wr(3'd5, t[7:0]);
    rd(3'd1, d);
    chk("R9 flag still set before clash", d, 8'h20);
    forever begin
      @(negedge clk);
      if (m_pre == 3 && m_cnt + 16'd1 == t) break;
    end
    bus_wr = 1; bus_addr = 3'd5; bus_wdata = t[7:0];
    @(negedge clk); bus_wr = 0;
    chk("R9 set wins over clear", irq_o, 1);
    wr(3'd5, t[7:0]); idle(1);
    chk("R9 clear disarmed by clash write", irq_o, 1);
    rd(3'd1, d); wr(3'd5, 8'h00);
    // R7 byte independence
    wr(3'd4, 8'h5A);
    rd(3'd5, d); chk("R7 high write keeps low", d, 8'h00);
    wr(3'd5, 8'hA5);
    rd(3'd4, d); chk("R7 low write keeps high", d, 8'h5A);
    rd(3'd5, d); chk("R7 low readback", d, 8'hA5);
    idle(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule